// File: doc/BRIEF.md
# Inter-core send command dispatcher

The dispatcher takes 64-bit send commands aimed at other cores and turns each one into a short sequence of register transactions on a request channel. Three kinds of command exist. A doorbell command rings one interrupt bit in the target core's set port. A mailbox command writes one 32-bit word into one of eight mailbox words of the target core. An arbitrary-address command writes one 32-bit word to any 16-bit address in the target core's register space. The mailbox and arbitrary-address commands carry a 4-bit byte-keep mask. When any mask bit is set, the dispatcher first reads the target word, then writes a word in which the masked bytes keep their old value and the other bytes take the command's payload.

Commands enter on a valid/ready port. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the sequencer is idle, so one command is in flight at a time. The request channel is also valid/ready. While `req_valid` is high and `req_ready` is low, the request fields are held unchanged, and the request completes on the edge where both are high. Read data comes back on `rsp_valid`/`rsp_rdata`, which has no back-pressure. The interconnect delivers exactly one response for each accepted read.

Command fields:
- Target core: bits 25:16.
- Byte-keep mask: bits 30:27. Bit 27+i covers byte i of the data word, where byte i is bits 8i+7:8i.
- Payload: bits 63:32.
- `cmd_kind` encoding: 2'b00 doorbell, 2'b01 mailbox, 2'b10 arbitrary address, 2'b11 reserved.

Top module: `ipi_send_dispatch`

## Requirements
- R1: Every emitted request carries the target core id taken from command bits 25:16 of the command that produced it.
- R2: A doorbell command (kind 2'b00) emits exactly one write, to address 16'h1008, with data 1 << cmd[4:0]. It issues no read, whatever bits 30:27 and 63:32 hold, and whatever the value of `cmd_full`.
- R3: A mailbox command (kind 2'b01) targets address 16'h1020 + 4*cmd[4:2]. Command bits 1:0 and 15:5 do not affect the address.
- R4: An arbitrary-address command (kind 2'b10) targets address cmd[15:0].
- R5: For a mailbox or arbitrary-address command whose mask cmd[30:27] is zero, no read is issued. A single write of cmd[63:32] follows.
- R6: For a mailbox or arbitrary-address command with a nonzero mask, exactly one read of the same core and address is issued first. The write that follows carries, for each byte i, the old byte when cmd[27+i] is 1 and the payload byte cmd[32+8i+7:32+8i] when it is 0.
- R7: Two kinds of command are accepted and dropped, so that no request is issued and the block stays idle. The first is a mailbox or arbitrary-address command with `cmd_full` low, meaning it was not a full 64-bit write. The second is any command of kind 2'b11.
- R8: From the edge that accepts a valid command until one cycle after its write request completes, `busy` is high and `cmd_ready` is low.
- R9: While `req_valid` is high and `req_ready` is low, `req_write`, `req_core`, `req_addr` and `req_wdata` stay stable, and `req_valid` stays high.
- R10: After reset the block is idle: `busy` is low, `req_valid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_kind | input | 2 | 00 doorbell, 01 mailbox, 10 arbitrary address, 11 reserved |
| cmd_full | input | 1 | High when the command came as a full 64-bit write |
| cmd_data | input | 64 | Command word |
| busy | output | 1 | A command is in flight |
| req_valid | output | 1 | Request offered to the interconnect |
| req_ready | input | 1 | Interconnect takes the request |
| req_write | output | 1 | 1 write, 0 read |
| req_core | output | 10 | Target core id |
| req_addr | output | 16 | Target register address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_rdata | input | 32 | Returned read data |

## Verification
All sixteen mask values are sent against a behavioural per-core memory, with a different old word each time. A merge with the byte sense inverted or with misplaced byte lanes would write the wrong word. A design that reads on a zero mask would show a read count it should not have. Doorbell commands carry mask bits and payload junk, and a sequencer that decodes the mask for every kind would issue a spurious read. Partial-width and reserved-kind commands are offered with nonzero masks, so a design that does not drop them would issue a stray read or corrupt memory. The request port is stalled in a repeating pattern during a masked command, which catches fields that move before acceptance.

// File: rtl/ipi_disp_pkg.sv
package ipi_disp_pkg;
  localparam int CMD_W      = 64;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 16;
  localparam int CORE_W     = 10;
  localparam int CORE_LSB   = 16;
  localparam int NBYTES     = DATA_W / 8;
  localparam int KEEP_LSB   = 27;
  localparam int PAYLD_LSB  = 32;
  localparam int VEC_W      = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] SET_PORT_ADDR = 16'h1008;
  localparam logic [ADDR_W-1:0] MBOX_BASE     = 16'h1020;

  typedef enum logic [1:0] {
    KIND_IPI  = 2'b00,
    KIND_MAIL = 2'b01,
    KIND_ANY  = 2'b10,
    KIND_RSVD = 2'b11
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_RDATA,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic              ok;
    logic [CORE_W-1:0] core;
    logic [ADDR_W-1:0] addr;
    logic [NBYTES-1:0] keep;
    logic [DATA_W-1:0] data;
  } xact_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_disp_pkg::*;
(
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_full,
  input  logic [CMD_W-1:0] cmd_data,
  output xact_t            xact
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_data[KEEP_LSB-1:CORE_LSB+CORE_W], cmd_data[PAYLD_LSB-1]};

  always_comb begin
    xact      = '0;
    xact.core = cmd_data[CORE_LSB +: CORE_W];
    case (cmd_kind)
      KIND_IPI: begin
        xact.ok   = 1'b1;
        xact.addr = SET_PORT_ADDR;
        xact.data = DATA_W'(1) << cmd_data[VEC_W-1:0];
      end
      KIND_MAIL: begin
        xact.ok   = cmd_full;
        xact.addr = MBOX_BASE + ADDR_W'({cmd_data[4:2], 2'b00});
        xact.keep = cmd_data[KEEP_LSB +: NBYTES];
        xact.data = cmd_data[PAYLD_LSB +: DATA_W];
      end
      KIND_ANY: begin
        xact.ok   = cmd_full;
        xact.addr = cmd_data[ADDR_W-1:0];
        xact.keep = cmd_data[KEEP_LSB +: NBYTES];
        xact.data = cmd_data[PAYLD_LSB +: DATA_W];
      end
      default: xact.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_byte_merge.sv
module ipi_byte_merge
  import ipi_disp_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [NBYTES-1:0] keep,
  output logic [DATA_W-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
  end
endmodule

// File: rtl/ipi_seq_fsm.sv
module ipi_seq_fsm
  import ipi_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  xact_t             dec,
  output logic              cmd_ready,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [CORE_W-1:0] req_core,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  seq_state_e        state;
  xact_t             cur;
  logic [DATA_W-1:0] merged;

  ipi_byte_merge u_merge (
    .old_word (rsp_rdata),
    .new_word (cur.data),
    .keep     (cur.keep),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid && dec.ok) begin
          cur   <= dec;
          state <= (|dec.keep) ? ST_READ : ST_WRITE;
        end
        ST_READ:       if (req_ready) state <= ST_WAIT_RDATA;
        ST_WAIT_RDATA: if (rsp_valid) begin
          cur.data <= merged;
          state    <= ST_WRITE;
        end
        ST_WRITE:      if (req_ready) state <= ST_DONE;
        default:       state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign req_valid = (state == ST_READ) || (state == ST_WRITE);
  assign req_write = (state == ST_WRITE);
  assign req_core  = cur.core;
  assign req_addr  = cur.addr;
  assign req_wdata = cur.data;
endmodule

// File: rtl/ipi_send_dispatch.sv
module ipi_send_dispatch
  import ipi_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_kind,
  input  logic              cmd_full,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [CORE_W-1:0] req_core,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  xact_t dec;

  ipi_cmd_decode u_decode (
    .cmd_kind (cmd_kind),
    .cmd_full (cmd_full),
    .cmd_data (cmd_data),
    .xact     (dec)
  );

  ipi_seq_fsm u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .dec       (dec),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_kind,
  input logic        cmd_full,
  input logic [63:0] cmd_data,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [9:0]  req_core,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata
);
  logic acc, wide, good, masked;
  assign acc    = cmd_valid && cmd_ready;
  assign wide   = (cmd_kind == 2'b01 || cmd_kind == 2'b10) && cmd_full;
  assign good   = (cmd_kind == 2'b00) || wide;
  assign masked = |cmd_data[30:27];

  logic unused_chk;
  assign unused_chk = ^{rsp_valid, rsp_rdata};

  p_core_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && good |=> req_valid && req_core == $past(cmd_data[25:16]));

  p_doorbell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_kind == 2'b00 |=> req_valid && req_write && req_addr == 16'h1008
      && $countones(req_wdata) == 1 && req_wdata == (32'd1 << $past(cmd_data[4:0])));

  p_mbox_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_kind == 2'b01 && cmd_full |=>
      req_addr == 16'h1020 + 16'({$past(cmd_data[4:2]), 2'b00}));

  p_any_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_kind == 2'b10 && cmd_full |=> req_addr == $past(cmd_data[15:0]));

  p_direct_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wide && !masked |=> req_valid && req_write && req_wdata == $past(cmd_data[63:32]));

  p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wide && masked |=> req_valid && !req_write);

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !good |=> !busy && !req_valid);

  p_done_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_ready |=> busy && !cmd_ready && !req_valid);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_core)
      && $stable(req_addr) && $stable(req_wdata));
endmodule

bind ipi_send_dispatch ipi_dispatch_chk u_chk (.*);

// File: tb/test_ipi_send_dispatch.sv
module test_ipi_send_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;
  localparam int NVEC       = 8;

  // entry: {kind[1:0], full, cmd[63:0], expected address[15:0]}
  localparam logic [82:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 64'h0000_0000_0005_0000, 16'h1008},
    {2'b00, 1'b1, 64'h0000_0000_03FF_001F, 16'h1008},
    {2'b00, 1'b0, 64'hDEAD_BEEF_7812_0007, 16'h1008},
    {2'b01, 1'b1, 64'h1122_3344_0003_0000, 16'h1020},
    {2'b01, 1'b1, 64'hA5A5_5A5A_0003_FFFF, 16'h103C},
    {2'b10, 1'b1, 64'h0BAD_F00D_0001_4567, 16'h4567},
    {2'b10, 1'b1, 64'hCAFE_BABE_2802_0100, 16'h0100},
    {2'b01, 1'b1, 64'h0101_0101_7804_0008, 16'h1028}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = 2'b00;
  logic        cmd_full = 1'b0;
  logic [63:0] cmd_data = '0;
  logic        busy;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic        req_write;
  logic [9:0]  req_core;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  logic [31:0] mem [int unsigned];
  int          wr_cnt = 0, rd_cnt = 0, cyc = 0;
  int unsigned last_wr_key = 0, last_rd_key = 0, pend_key = 0;
  logic [31:0] last_wr_data = '0;
  bit          pend = 0, stall_en = 0, hold_prev = 0;
  logic        p_write;
  logic [9:0]  p_core;
  logic [15:0] p_addr;
  logic [31:0] p_wdata;

  ipi_send_dispatch i_ipi_send_dispatch (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned key_of(input logic [9:0] c, input logic [15:0] a);
    return {6'd0, c, a};
  endfunction

  function automatic logic [31:0] peek(input int unsigned k);
    if (mem.exists(k)) return mem[k];
    return (k * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural interconnect plus per-core target memory
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_rdata = peek(pend_key);
      pend = 0;
    end
    if (rst_n && hold_prev) begin
      chk(req_valid && req_write == p_write && req_core == p_core && req_addr == p_addr
          && req_wdata == p_wdata, "R9 stalled request stable",
          {req_write, req_core, req_addr, req_wdata}, {p_write, p_core, p_addr, p_wdata});
    end
    req_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
    if (rst_n && req_valid && req_ready) begin
      if (req_write) begin
        mem[key_of(req_core, req_addr)] = req_wdata;
        wr_cnt++;
        last_wr_key  = key_of(req_core, req_addr);
        last_wr_data = req_wdata;
      end else begin
        pend = 1;
        pend_key = key_of(req_core, req_addr);
        last_rd_key = pend_key;
        rd_cnt++;
      end
    end
    hold_prev = rst_n && req_valid && !req_ready;
    p_write = req_write; p_core = req_core; p_addr = req_addr; p_wdata = req_wdata;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_cmd(input logic [1:0] kind, input logic full, input logic [63:0] cmd,
                         input logic [15:0] exp_addr, input string tag);
    logic [9:0]  core = cmd[25:16];
    int unsigned k    = key_of(core, exp_addr);
    logic [31:0] old  = peek(k);
    bit          ok   = (kind == 2'b00) || ((kind == 2'b01 || kind == 2'b10) && full);
    bit          rd   = ok && kind != 2'b00 && cmd[30:27] != 4'd0;
    int          w0   = wr_cnt;
    int          r0   = rd_cnt;
    logic [31:0] exp;
    if (kind == 2'b00) exp = 32'd1 << cmd[4:0];
    else for (int b = 0; b < 4; b++)
      exp[8*b +: 8] = cmd[27+b] ? old[8*b +: 8] : cmd[32+8*b +: 8];
    @(negedge clk);
    cmd_kind = kind; cmd_full = full; cmd_data = cmd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == ok && cmd_ready == !ok, {"R8 busy after accept ", tag}, {busy, cmd_ready}, {ok, !ok});
    while (busy) @(negedge clk);
    if (ok) begin
      chk(wr_cnt == w0 + 1, {"R2/R5 one write ", tag}, wr_cnt - w0, 1);
      chk(rd_cnt == r0 + int'(rd), {"R5/R6 read count ", tag}, rd_cnt - r0, int'(rd));
      chk(last_wr_key == k, {"R1/R3/R4 core and address ", tag}, last_wr_key, k);
      chk(last_wr_data == exp, {"R6 written word ", tag}, last_wr_data, exp);
      if (rd) chk(last_rd_key == k, {"R6 read target ", tag}, last_rd_key, k);
    end else begin
      chk(wr_cnt == w0 && rd_cnt == r0, {"R7 dropped ", tag}, {wr_cnt - w0, rd_cnt - r0}, 0);
      chk(peek(k) == old, {"R7 memory untouched ", tag}, peek(k), old);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req_valid && cmd_ready, "R10 reset state", {busy, req_valid, cmd_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req_valid && cmd_ready, "R10 idle after reset", {busy, req_valid, cmd_ready}, 3'b001);

    for (int v = 0; v < NVEC; v++)
      run_cmd(VEC[v][82:81], VEC[v][80], VEC[v][79:16], VEC[v][15:0], $sformatf("vec%0d", v));

    // R6 every mask value on mailbox word 3 of core 9
    for (int m = 0; m < 16; m++)
      run_cmd(2'b01, 1'b1, {32'h89AB_CDEF ^ (32'h0101_0101 * m), 1'b0, m[3:0], 27'h0009_000C},
              16'h102C, $sformatf("mask%0d", m));

    // R7 partial-width and reserved-kind commands
    run_cmd(2'b01, 1'b0, 64'hFFFF_FFFF_7807_0004, 16'h1024, "mail partial");
    run_cmd(2'b10, 1'b0, 64'hFFFF_FFFF_0807_2000, 16'h2000, "any partial");
    run_cmd(2'b11, 1'b1, 64'hFFFF_FFFF_0807_2000, 16'h2000, "reserved kind");

    // R9 stalled request port during a masked and an unmasked command
    stall_en = 1;
    run_cmd(2'b10, 1'b1, 64'h1357_9BDF_5003_0200, 16'h0200, "stall masked");
    run_cmd(2'b01, 1'b1, 64'h2468_ACE0_0003_0010, 16'h1030, "stall direct");
    run_cmd(2'b00, 1'b1, 64'h0000_0000_0006_0010, 16'h1008, "stall doorbell");
    stall_en = 0;

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule